// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

While a flash memory runs an internal program or erase, a host that reads the device gets a status byte instead of array contents. This block builds that byte. On each rising edge of the read strobe it registers either the status byte or the array byte onto `dq_o`, and holds it until the next read. The operation type, the bit being programmed, the sectors chosen for erase and their protection flags, the error flag and the sector-erase time-out state are all plain inputs. The block has no knowledge of the array, the charge pump or the command decoder.

Four status bits carry the information. Bit 7 is a data-polling bit. Bit 6 flips on every read. Bit 5 reports an error. Bit 3 reports the erase time-out. Two timed windows are built from parameterised cycle counters. The first is a protected-erase window, in which bits 7 and 6 are forced low when every selected sector is protected; after it, reads fall back to array data because no erase takes place. The second is an erase-suspend window, in which reads of a sector other than the suspended one show a toggling bit 6 for a limited time. `busy_o` is high while either window runs.

Top module: `flash_status_reporter`

## Requirements
- R1: Operation code encoding on `op_i`: 0 idle, 1 program, 2 block erase, 3 sector erase, 4 erase suspend; codes 5 to 7 behave as idle. While idle, a read registers `array_i` unchanged onto `dq_o`.
- R2: During program, a read gives bit 7 = inverse of `prog_bit_i`, bit 3 = 0, and bits 4, 2, 1, 0 = 0.
- R3: Bit 6 of a status read starts at 0 on the first read after `op_i` changes and inverts on each later toggling read. A strobe held high for several cycles counts as a single read.
- R4: In program and erase status reads, bit 5 equals `err_i`.
- R5: During block or sector erase, a status read gives bit 7 = 0 and bits 4, 2, 1, 0 = 0. For block erase, bit 3 = 1.
- R6: During sector erase, bit 3 equals `erase_tmo_i` (0 while more sectors may still be added, 1 after the time-out).
- R7: When `op_i` enters an erase code and every sector set in `erase_sel_i` is also set in `sect_prot_i` (with at least one selected), `busy_o` is high for exactly PROT_CYC cycles, starting in the first cycle the erase code is present. Reads in that window give bits 7 and 6 = 0 and do not advance the toggle.
- R8: After the protected window ends, reads return `array_i` until `op_i` leaves the erase codes.
- R9: In erase suspend, a read with `rd_sector_i` equal to `susp_sector_i` returns INV_BYTE (default 0xFF) and does not advance the toggle.
- R10: On entering erase suspend, `busy_o` is high for exactly SUSP_CYC cycles. A read of another sector in that window returns `array_i` with bit 6 replaced by the toggle bit.
- R11: After the suspend window, reads of other sectors return `array_i` unchanged.
- R12: `dq_o` changes only at a clock edge that sees the strobe rising; otherwise it holds.
- R13: After reset, `dq_o` is 0 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Running operation code |
| prog_bit_i | input | 1 | Data bit being programmed (polling reference) |
| err_i | input | 1 | Program or erase failure flag |
| erase_tmo_i | input | 1 | Sector-erase time-out expired |
| erase_sel_i | input | NSECT | Sectors selected for erase |
| sect_prot_i | input | NSECT | Per-sector protection flags |
| susp_sector_i | input | SECT_W | Sector whose erase is suspended |
| rd_sector_i | input | SECT_W | Sector addressed by the current read |
| rd_stb_i | input | 1 | Read strobe; rising edge starts one read |
| array_i | input | 8 | Array data for the addressed byte |
| dq_o | output | 8 | Byte returned to the host |
| busy_o | output | 1 | A protected or suspend window is running |

## Verification
Two functions can meet in one cycle: a read edge and the start or end of a timed window. The bench raises the strobe in the very cycle that `op_i` first shows a fully protected erase, and again in the cycle that the erase-suspend code first appears. Those reads must already show the window's behaviour: bits 7 and 6 forced low in the first case, and the invalid byte for the suspended sector in the second. It also places a read exactly on the last cycle of the protected window, which must still be forced low, and on the cycle just after it, which must show array data.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_BERASE = 3'd2,
    OP_SERASE = 3'd3,
    OP_SUSP   = 3'd4
  } op_e;

  function automatic logic is_erase(input logic [2:0] op);
    return (op == OP_BERASE) || (op == OP_SERASE);
  endfunction

  function automatic logic is_susp(input logic [2:0] op);
    return op == OP_SUSP;
  endfunction

endpackage

// File: rtl/fsr_window.sv
// Timed window: active from the start cycle for LEN cycles, then a sticky
// expired flag until the owning mode is left.
module fsr_window #(
  parameter int LEN = 4,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic active_o,
  output logic done_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    active_o = (start_i | (cnt_q != '0)) & ~clear_i;
    if (clear_i)
      cnt_d = '0;
    else if (start_i)
      cnt_d = CW'(LEN - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    else
      cnt_d = cnt_q;
    done_d = ~clear_i & (done_q | (active_o & (cnt_d == '0)));
    cnt_en = (cnt_d != cnt_q) | (done_d != done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/fsr_toggle.sv
// Read-edge detector and toggle bit. The toggle seen by a read is 0 on the
// first read after an operation change.
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic new_op_i,
  input  logic adv_i,
  output logic rd_ev_o,
  output logic tog_o
);

  logic stb_q;
  logic tog_q, tog_d;
  logic tog_en;

  always_comb begin
    rd_ev_o = stb_i & ~stb_q;
    tog_o   = new_op_i ? 1'b0 : tog_q;
    tog_d   = (rd_ev_o & adv_i) ? ~tog_o : tog_o;
    tog_en  = tog_d != tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

endmodule

// File: rtl/fsr_compose.sv
// Selects the byte for the current read and whether it advances the toggle.
module fsr_compose #(
  parameter logic [7:0] INV_BYTE = 8'hFF
) (
  input  logic [2:0] op_i,
  input  logic       prog_bit_i,
  input  logic       err_i,
  input  logic       erase_tmo_i,
  input  logic       tog_i,
  input  logic [7:0] array_i,
  input  logic       prot_act_i,
  input  logic       prot_done_i,
  input  logic       susp_act_i,
  input  logic       sect_hit_i,
  output logic [7:0] byte_o,
  output logic       adv_o
);
  import fsr_pkg::*;

  logic dq3;

  always_comb begin
    dq3    = (op_i == OP_BERASE) ? 1'b1 : erase_tmo_i;
    byte_o = array_i;
    adv_o  = 1'b0;
    case (op_i)
      OP_PROG: begin
        byte_o = {~prog_bit_i, tog_i, err_i, 1'b0, 1'b0, 3'b000};
        adv_o  = 1'b1;
      end
      OP_BERASE, OP_SERASE: begin
        if (prot_act_i) begin
          byte_o = {1'b0, 1'b0, err_i, 1'b0, dq3, 3'b000};
        end else if (!prot_done_i) begin
          byte_o = {1'b0, tog_i, err_i, 1'b0, dq3, 3'b000};
          adv_o  = 1'b1;
        end
      end
      OP_SUSP: begin
        if (sect_hit_i) begin
          byte_o = INV_BYTE;
        end else if (susp_act_i) begin
          byte_o = {array_i[7], tog_i, array_i[5:0]};
          adv_o  = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
  parameter int         NSECT    = 8,
  parameter int         PROT_CYC = 400,
  parameter int         SUSP_CYC = 60,
  parameter logic [7:0] INV_BYTE = 8'hFF,
  localparam int        SECT_W   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic              prog_bit_i,
  input  logic              err_i,
  input  logic              erase_tmo_i,
  input  logic [NSECT-1:0]  erase_sel_i,
  input  logic [NSECT-1:0]  sect_prot_i,
  input  logic [SECT_W-1:0] susp_sector_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  logic              rd_stb_i,
  input  logic [7:0]        array_i,
  output logic [7:0]        dq_o,
  output logic              busy_o
);
  import fsr_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [2:0] op_q;
  logic       new_op, all_prot;
  logic       prot_start, prot_clear, prot_act, prot_done;
  logic       susp_start, susp_clear, susp_act, susp_done;
  logic       rd_ev, tog, adv, sect_hit;
  logic [7:0] byte_sel, dq_q, dq_d;

  always_comb begin
    new_op     = op_i != op_q;
    all_prot   = (|erase_sel_i) & ~(|(erase_sel_i & ~sect_prot_i));
    prot_start = is_erase(op_i) & ~is_erase(op_q) & all_prot;
    prot_clear = ~is_erase(op_i);
    susp_start = is_susp(op_i) & ~is_susp(op_q);
    susp_clear = ~is_susp(op_i);
    sect_hit   = rd_sector_i == susp_sector_i;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) op_q <= OP_IDLE;
    else        op_q <= op_i;
  end

  fsr_window #(.LEN(PROT_CYC)) u_prot_win (
    .clk      (clk),
    .rst_n    (rst_s),
    .start_i  (prot_start),
    .clear_i  (prot_clear),
    .active_o (prot_act),
    .done_o   (prot_done)
  );

  fsr_window #(.LEN(SUSP_CYC)) u_susp_win (
    .clk      (clk),
    .rst_n    (rst_s),
    .start_i  (susp_start),
    .clear_i  (susp_clear),
    .active_o (susp_act),
    .done_o   (susp_done)
  );

  fsr_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_s),
    .stb_i    (rd_stb_i),
    .new_op_i (new_op),
    .adv_i    (adv),
    .rd_ev_o  (rd_ev),
    .tog_o    (tog)
  );

  fsr_compose #(.INV_BYTE(INV_BYTE)) u_compose (
    .op_i        (op_i),
    .prog_bit_i  (prog_bit_i),
    .err_i       (err_i),
    .erase_tmo_i (erase_tmo_i),
    .tog_i       (tog),
    .array_i     (array_i),
    .prot_act_i  (prot_act),
    .prot_done_i (prot_done),
    .susp_act_i  (susp_act),
    .sect_hit_i  (sect_hit),
    .byte_o      (byte_sel),
    .adv_o       (adv)
  );

  // output byte register, loaded on a read edge only
  always_comb dq_d = byte_sel;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     dq_q <= 8'h00;
    else if (rd_ev) dq_q <= dq_d;
  end

  assign dq_o   = dq_q;
  assign busy_o = prot_act | susp_act;

  logic unused_ok;
  assign unused_ok = susp_done;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int         PROT_CYC = 400,
  parameter logic [7:0] INV_BYTE = 8'hFF,
  parameter int         SECT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic              prog_bit_i,
  input logic              err_i,
  input logic              rd_stb_i,
  input logic [SECT_W-1:0] rd_sector_i,
  input logic [SECT_W-1:0] susp_sector_i,
  input logic [7:0]        array_i,
  input logic [7:0]        dq_o,
  input logic              busy_o
);
  localparam int BW = $clog2(PROT_CYC + 1) + 1;

  logic          stb_seen;
  logic          rd_edge;
  logic          erase_now;
  logic [BW-1:0] busy_run;

  assign rd_edge   = rd_stb_i & ~stb_seen;
  assign erase_now = (op_i == 3'd2) || (op_i == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_seen <= 1'b0;
      busy_run <= '0;
    end else begin
      stb_seen <= rd_stb_i;
      if (busy_o && erase_now) busy_run <= busy_run + BW'(1);
      else                     busy_run <= '0;
    end
  end

  a_r12_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_edge |=> $stable(dq_o));

  a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && op_i == 3'd0) |=> dq_o == $past(array_i));

  a_r2_program_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && op_i == 3'd1) |=> dq_o[7] == !$past(prog_bit_i));

  a_r4_error_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && op_i == 3'd1) |=> dq_o[5] == $past(err_i));

  a_r9_invalid_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && op_i == 3'd4 && rd_sector_i == susp_sector_i) |=> dq_o == INV_BYTE);

  a_r7_window_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && busy_o && erase_now) |=> dq_o[7:6] == 2'b00);

  a_r7_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && erase_now) |-> busy_run < BW'(PROT_CYC));

endmodule

bind flash_status_reporter fsr_checker #(
  .PROT_CYC (PROT_CYC),
  .INV_BYTE (INV_BYTE),
  .SECT_W   (SECT_W)
) u_fsr_checker (
  .clk           (clk),
  .rst_n         (rst_s),
  .op_i          (op_i),
  .prog_bit_i    (prog_bit_i),
  .err_i         (err_i),
  .rd_stb_i      (rd_stb_i),
  .rd_sector_i   (rd_sector_i),
  .susp_sector_i (susp_sector_i),
  .array_i       (array_i),
  .dq_o          (dq_o),
  .busy_o        (busy_o)
);

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int P_CYC = 40;
  localparam int S_CYC = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op;
  logic       pbit, err, tmo, stb;
  logic [NS-1:0] esel, prot;
  logic [2:0] ssec, rsec;
  logic [7:0] arr;
  logic [7:0] dq;
  logic       busy;

  int total = 0;
  int bad = 0;
  int edges = 0;
  logic mtog;
  logic [2:0] prev_op;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  flash_status_reporter #(.NSECT(NS), .PROT_CYC(P_CYC), .SUSP_CYC(S_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .prog_bit_i(pbit), .err_i(err),
    .erase_tmo_i(tmo), .erase_sel_i(esel), .sect_prot_i(prot),
    .susp_sector_i(ssec), .rd_sector_i(rsec), .rd_stb_i(stb),
    .array_i(arr), .dq_o(dq), .busy_o(busy));

  function automatic logic [7:0] model_byte(input logic [2:0] o, input logic pb,
      input logic e, input logic t, input logic tg, input logic [7:0] a);
    case (o)
      3'd1:    return {~pb, tg, e, 1'b0, 1'b0, 3'b000};
      3'd2:    return {1'b0, tg, e, 1'b0, 1'b1, 3'b000};
      3'd3:    return {1'b0, tg, e, 1'b0, t, 3'b000};
      default: return a;
    endcase
  endfunction

  function automatic logic model_adv(input logic [2:0] o);
    return (o == 3'd1) || (o == 3'd2) || (o == 3'd3);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts just after a negedge; read captured at the next posedge
  task automatic do_read(output logic [7:0] r);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    #1 r = dq;
    @(negedge clk);
  endtask

  task automatic go_idle();
    op = 3'd0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int sd;
    sd = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; op = 3'd0; pbit = 0; err = 0; tmo = 0; stb = 0;
    esel = '0; prot = '0; ssec = 3'd0; rsec = 3'd0; arr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 dq after reset", dq, 8'h00);
    chk("R13 busy after reset", {7'b0, busy}, 8'h00);

    // R1 idle passthrough, R12 hold
    arr = 8'h3C; do_read(got); chk("R1 idle read", got, 8'h3C);
    arr = 8'hC3; repeat (3) @(negedge clk);
    chk("R12 hold without strobe", dq, 8'h3C);

    // R3 strobe held high counts once
    op = 3'd1; pbit = 1'b0; err = 1'b0;
    do_read(got); chk("R2 program first read", got, 8'h80);
    stb = 1'b1; repeat (4) @(negedge clk); stb = 1'b0; #1 got = dq;
    chk("R3 held strobe single toggle", got, 8'hC0);
    @(negedge clk);
    do_read(got); chk("R3 next read toggles back", got, 8'h80);
    go_idle();

    // random phases over program / erase / idle
    prev_op = 3'd0; mtog = 1'b0;
    for (int i = 0; i < 150; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 3));
      prot = '0;
      esel = 8'h01 | 8'($urandom);
      op = o;
      if (o != prev_op) mtog = 1'b0;
      prev_op = o;
      for (int k = 0; k < 3; k++) begin
        logic [7:0] e;
        pbit = 1'($urandom); err = 1'($urandom); tmo = 1'($urandom); arr = 8'($urandom);
        e = model_byte(o, pbit, err, tmo, mtog, arr);
        do_read(got);
        case (o)
          3'd0: chk("R1 random idle", got, e);
          3'd1: chk("R2 R3 R4 random program", got, e);
          3'd2: chk("R5 R3 R4 random block erase", got, e);
          default: chk("R6 R3 R4 random sector erase", got, e);
        endcase
        if (model_adv(o)) mtog = ~mtog;
      end
    end
    go_idle();

    // R7 protected erase, read in the very first window cycle
    begin
      int e0, span;
      esel = 8'h0C; prot = 8'h8C; err = 1'b1; arr = 8'hFF;
      op = 3'd2; stb = 1'b1;
      #1 chk("R7 busy at window start", {7'b0, busy}, 8'h01);
      e0 = edges;
      @(negedge clk); stb = 1'b0; #1 got = dq;
      chk("R7 forced read at start", got, 8'h28);
      @(negedge clk);
      do_read(got); chk("R7 forced read inside window", got, 8'h28);
      forever begin
        #1 if (!busy) break;
        @(negedge clk);
      end
      span = edges - e0;
      chk("R7 window length", 8'(span), 8'(P_CYC));
      arr = 8'h96;
      do_read(got); chk("R8 array after window", got, 8'h96);
      arr = 8'h69;
      do_read(got); chk("R8 array stays after window", got, 8'h69);
      go_idle();
    end

    // R7/R8 boundary: read on last window cycle, then just after
    esel = 8'h40; prot = 8'h40; err = 1'b0; tmo = 1'b0; arr = 8'hA5;
    op = 3'd3;
    repeat (P_CYC - 1) @(negedge clk);
    do_read(got); chk("R7 read on last window cycle", got, 8'h00);
    chk("R7 busy low after window", {7'b0, busy}, 8'h00);
    do_read(got); chk("R8 read just after window", got, 8'hA5);
    go_idle();

    // R6 unprotected sector erase, time-out states
    esel = 8'h03; prot = 8'h01; err = 1'b0; tmo = 1'b0; op = 3'd3;
    do_read(got); chk("R6 before time-out", got, 8'h00);
    tmo = 1'b1;
    do_read(got); chk("R6 after time-out", got, 8'h48);
    go_idle();

    // R9 R10 R11 suspend, invalid read in the start cycle
    begin
      int e0, span;
      ssec = 3'd3; rsec = 3'd3; arr = 8'h5A;
      op = 3'd4; stb = 1'b1;
      #1 chk("R10 busy at suspend start", {7'b0, busy}, 8'h01);
      e0 = edges;
      @(negedge clk); stb = 1'b0; #1 got = dq;
      chk("R9 suspended sector invalid", got, 8'hFF);
      @(negedge clk);
      rsec = 3'd5; arr = 8'hC7;
      do_read(got); chk("R10 other sector first toggle", got, 8'h87);
      arr = 8'h07;
      do_read(got); chk("R10 other sector second toggle", got, 8'h47);
      forever begin
        #1 if (!busy) break;
        @(negedge clk);
      end
      span = edges - e0;
      chk("R10 suspend window length", 8'(span), 8'(S_CYC));
      arr = 8'h47;
      do_read(got); chk("R11 array after suspend window", got, 8'h47);
      rsec = 3'd3;
      do_read(got); chk("R9 suspended sector still invalid", got, 8'hFF);
      go_idle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule